// File: doc/BRIEF.md
# Integer Issue Queue with Dual-ALU Steering

This block holds decoded integer instructions between rename and execution and sends them to two integer ALUs out of program order. It has sixteen entries. Each cycle up to four new instructions arrive on a dispatch port, each carrying a class code, two source physical-register tags with ready flags, a destination tag and a completion identifier. Waiting sources become ready when a result-tag broadcast names them. Up to three broadcasts can arrive per cycle.

Each cycle the queue picks at most one fully ready entry for each ALU and presents it on that ALU's issue port. The issue port carries the source tags for the register read, the destination tag and the completion identifier. The two ports are not alike. Branch and shift work may only go to the first ALU. Multiply and divide may only go to the second. Plain arithmetic may go to either. Once a divide leaves on the second port, that port stays closed for the whole divide. An entry is given up at the clock edge where it issues, and a flush empties the whole queue in one edge.

Top module: `int_issue_queue`

## Requirements
- R1: The queue has DEPTH (16) entries and is empty after reset. `disp_ready` is high exactly when `flush` is low and the number of free entries at the start of the cycle is at least the number of asserted `disp_valid` lanes. When `disp_ready` is low, no lane is written.
- R2: Accepted lanes fill free entries in lane order. The lowest-numbered valid lane takes the lowest-indexed free entry, the next valid lane takes the next free entry, and so on. Lanes whose valid bit is low take no entry.
- R3: A source is ready if its ready flag was set at dispatch, or if a wakeup lane with its valid bit set carries the same tag in the dispatch cycle or any later cycle. A wakeup lane whose valid bit is low has no effect. An entry may issue only when both sources are ready, and at the earliest in the cycle after the edge that made it ready.
- R4: Class codes are 0 = simple, 1 = branch/shift, 2 = multiply, 3 = divide. Port 1 issues only codes 0 and 1. It takes the lowest-indexed ready code-1 entry, or, if there is none, the lowest-indexed ready code-0 entry. It issues nothing while `alu1_busy` is high.
- R5: Port 2 issues only codes 0, 2 and 3. It takes the lowest-indexed ready code-2 or code-3 entry, or, if there is none, the lowest-indexed ready code-0 entry that port 1 did not take in the same cycle. It issues nothing while `alu2_busy` is high.
- R6: After port 2 issues a divide (code 3), port 2 issues nothing for the DIV_CYCLES cycles that follow.
- R7: An issued entry becomes free at the next clock edge and may be allocated from the following cycle on. The issue port presents the entry's class, both source tags, destination tag and identifier in the cycle it is valid.
- R8: While `flush` is high, both issue ports are idle and dispatch is refused. At the next edge every entry becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every queued instruction |
| disp_valid | input | DISP_W | Per-lane dispatch request |
| disp_class | input | DISP_W x 2 | Per-lane class code |
| disp_src1 | input | DISP_W x TAG_W | First source tag |
| disp_src1_rdy | input | DISP_W | First source already available |
| disp_src2 | input | DISP_W x TAG_W | Second source tag |
| disp_src2_rdy | input | DISP_W | Second source already available |
| disp_dst | input | DISP_W x TAG_W | Destination tag |
| disp_id | input | DISP_W x ID_W | Completion identifier |
| disp_ready | output | 1 | All offered lanes accepted this cycle |
| wake_valid | input | WAKE_W | Per-lane result broadcast valid |
| wake_tag | input | WAKE_W x TAG_W | Broadcast destination tags |
| alu1_busy | input | 1 | ALU 1 cannot take work |
| alu2_busy | input | 1 | ALU 2 cannot take work |
| iss1_valid | output | 1 | Port 1 issues this cycle |
| iss1_class | output | 2 | Port 1 class code |
| iss1_src1 | output | TAG_W | Port 1 first source tag |
| iss1_src2 | output | TAG_W | Port 1 second source tag |
| iss1_dst | output | TAG_W | Port 1 destination tag |
| iss1_id | output | ID_W | Port 1 completion identifier |
| iss2_valid | output | 1 | Port 2 issues this cycle |
| iss2_class | output | 2 | Port 2 class code |
| iss2_src1 | output | TAG_W | Port 2 first source tag |
| iss2_src2 | output | TAG_W | Port 2 second source tag |
| iss2_dst | output | TAG_W | Port 2 destination tag |
| iss2_id | output | ID_W | Port 2 completion identifier |

## Verification
The bench goes after the cases where a wrong design would misbehave quietly. A wakeup that lands in the dispatch cycle would be lost by a design that only compares tags against stored entries, and that instruction would wait forever. A lower-indexed simple entry and a higher-indexed branch both ready for port 1 would show inverted priority. A plain instruction eligible for both ports could be issued twice by a design that does not exclude port 1's pick from port 2. Two more cases concern the second port and back-pressure: a divide followed by a ready multiply shows whether port 2 reopens one cycle too early or too late, and offering more lanes than there are free entries exposes a design that accepts part of a group or writes over a live entry.

// File: rtl/iq_pkg.sv
package iq_pkg;

  localparam int CLS_W = 2;

  // class codes decoded by the steering logic
  typedef enum logic [CLS_W-1:0] {
    CLS_SIMPLE = 2'd0,
    CLS_BRSH   = 2'd1,
    CLS_MUL    = 2'd2,
    CLS_DIV    = 2'd3
  } iq_class_e;

endpackage

// File: rtl/iq_slot.sv
module iq_slot
  import iq_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int ID_W   = 5,
  parameter int WAKE_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           wr_en,
  input  logic [CLS_W-1:0]               wr_cls,
  input  logic [TAG_W-1:0]               wr_src1,
  input  logic                           wr_src1_rdy,
  input  logic [TAG_W-1:0]               wr_src2,
  input  logic                           wr_src2_rdy,
  input  logic [TAG_W-1:0]               wr_dst,
  input  logic [ID_W-1:0]                wr_id,
  input  logic                           clear,
  input  logic [WAKE_W-1:0]              wake_valid,
  input  logic [WAKE_W-1:0][TAG_W-1:0]   wake_tag,
  output logic                           valid_o,
  output logic                           ready_o,
  output logic [CLS_W-1:0]               cls_o,
  output logic [TAG_W-1:0]               src1_o,
  output logic [TAG_W-1:0]               src2_o,
  output logic [TAG_W-1:0]               dst_o,
  output logic [ID_W-1:0]                id_o
);

  // true when any live broadcast names the given tag
  function automatic logic tag_hit(
    input logic [TAG_W-1:0]             t,
    input logic [WAKE_W-1:0]            v,
    input logic [WAKE_W-1:0][TAG_W-1:0] bt
  );
    logic h;
    h = 1'b0;
    for (int w = 0; w < WAKE_W; w++) begin
      if (v[w] && (bt[w] == t)) h = 1'b1;
    end
    return h;
  endfunction

  logic             vld_q, r1_q, r2_q;
  logic [CLS_W-1:0] cls_q;
  logic [TAG_W-1:0] s1_q, s2_q, dst_q;
  logic [ID_W-1:0]  id_q;

  logic hit1_held, hit2_held, hit1_new, hit2_new;

  always_comb begin
    hit1_held = tag_hit(s1_q, wake_valid, wake_tag);
    hit2_held = tag_hit(s2_q, wake_valid, wake_tag);
    hit1_new  = tag_hit(wr_src1, wake_valid, wake_tag);
    hit2_new  = tag_hit(wr_src2, wake_valid, wake_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      r1_q  <= 1'b0;
      r2_q  <= 1'b0;
      cls_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      dst_q <= '0;
      id_q  <= '0;
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (wr_en) begin
      vld_q <= 1'b1;
      cls_q <= wr_cls;
      s1_q  <= wr_src1;
      s2_q  <= wr_src2;
      dst_q <= wr_dst;
      id_q  <= wr_id;
      r1_q  <= wr_src1_rdy | hit1_new;
      r2_q  <= wr_src2_rdy | hit2_new;
    end else begin
      if (clear) vld_q <= 1'b0;
      if (hit1_held) r1_q <= 1'b1;
      if (hit2_held) r2_q <= 1'b1;
    end
  end

  assign valid_o = vld_q;
  assign ready_o = r1_q & r2_q;
  assign cls_o   = cls_q;
  assign src1_o  = s1_q;
  assign src2_o  = s2_q;
  assign dst_o   = dst_q;
  assign id_o    = id_q;

  // allocation must only ever target an empty entry
  assert_write_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !vld_q);

  // the issue logic must only release a live entry
  assert_clear_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> vld_q);

  // a source once ready stays ready while the entry lives
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && r1_q && !clear && !flush) |=> r1_q);

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic [DEPTH-1:0]               free_vec,
  input  logic [DISP_W-1:0]              lane_valid,
  output logic                           accept,
  output logic [DISP_W-1:0][DEPTH-1:0]   lane_grant
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [CNT_W-1:0] count_slots(input logic [DEPTH-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] count_lanes(input logic [DISP_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int k = 0; k < DISP_W; k++) n = n + CNT_W'(v[k]);
    return n;
  endfunction

  // isolate the least significant set bit
  function automatic logic [DEPTH-1:0] low_bit(input logic [DEPTH-1:0] v);
    return v & (~v + DEPTH'(1));
  endfunction

  logic [CNT_W-1:0] free_cnt, offer_cnt;
  logic [DEPTH-1:0] remain;

  always_comb begin
    free_cnt  = count_slots(free_vec);
    offer_cnt = count_lanes(lane_valid);
    accept    = !flush && (free_cnt >= offer_cnt);
  end

  // successive valid lanes take successive free entries
  always_comb begin
    remain = free_vec;
    for (int k = 0; k < DISP_W; k++) begin
      lane_grant[k] = '0;
      if (lane_valid[k]) begin
        lane_grant[k] = low_bit(remain);
        remain        = remain & ~lane_grant[k];
      end
    end
  end

  // a full queue refuses any offered lane
  assert_full_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((free_vec == '0) && (lane_valid != '0)) |-> !accept);

  // an accepted lane always receives exactly one entry
  assert_lane_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (($countones(lane_grant[0]) == 32'(lane_valid[0]))));

endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0]             cand,
  input  logic [DEPTH-1:0][CLS_W-1:0]  slot_cls,
  input  logic                         alu1_open,
  input  logic                         alu2_open,
  output logic [DEPTH-1:0]             pick1,
  output logic [DEPTH-1:0]             pick2
);

  function automatic logic [DEPTH-1:0] low_bit(input logic [DEPTH-1:0] v);
    return v & (~v + DEPTH'(1));
  endfunction

  logic [DEPTH-1:0] m_brsh, m_simple, m_muldiv;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      m_brsh[i]   = cand[i] && (slot_cls[i] == CLS_BRSH);
      m_simple[i] = cand[i] && (slot_cls[i] == CLS_SIMPLE);
      m_muldiv[i] = cand[i] && ((slot_cls[i] == CLS_MUL) || (slot_cls[i] == CLS_DIV));
    end
  end

  always_comb begin
    pick1 = '0;
    if (alu1_open) begin
      pick1 = (m_brsh != '0) ? low_bit(m_brsh) : low_bit(m_simple);
    end
    pick2 = '0;
    if (alu2_open) begin
      pick2 = (m_muldiv != '0) ? low_bit(m_muldiv) : low_bit(m_simple & ~pick1);
    end
  end

endmodule

// File: rtl/iq_div_timer.sv
module iq_div_timer #(
  parameter int DIV_CYCLES = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle
);

  localparam int CW = $clog2(DIV_CYCLES + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               remain_q <= '0;
    else if (start)           remain_q <= CW'(DIV_CYCLES);
    else if (remain_q != '0)  remain_q <= remain_q - CW'(1);
  end

  assign idle = (remain_q == '0);

  // a divide that starts closes the port from the next cycle
  assert_div_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !idle);

  // the window shrinks by one each cycle until it ends
  assert_div_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !start) |=> (remain_q == $past(remain_q) - CW'(1)));

endmodule

// File: rtl/int_issue_queue.sv
module int_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DISP_W     = 4,
  parameter int WAKE_W     = 3,
  parameter int TAG_W      = 6,
  parameter int ID_W       = 5,
  parameter int DIV_CYCLES = 18
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic [DISP_W-1:0]              disp_valid,
  input  logic [DISP_W-1:0][1:0]         disp_class,
  input  logic [DISP_W-1:0][TAG_W-1:0]   disp_src1,
  input  logic [DISP_W-1:0]              disp_src1_rdy,
  input  logic [DISP_W-1:0][TAG_W-1:0]   disp_src2,
  input  logic [DISP_W-1:0]              disp_src2_rdy,
  input  logic [DISP_W-1:0][TAG_W-1:0]   disp_dst,
  input  logic [DISP_W-1:0][ID_W-1:0]    disp_id,
  output logic                           disp_ready,
  input  logic [WAKE_W-1:0]              wake_valid,
  input  logic [WAKE_W-1:0][TAG_W-1:0]   wake_tag,
  input  logic                           alu1_busy,
  input  logic                           alu2_busy,
  output logic                           iss1_valid,
  output logic [1:0]                     iss1_class,
  output logic [TAG_W-1:0]               iss1_src1,
  output logic [TAG_W-1:0]               iss1_src2,
  output logic [TAG_W-1:0]               iss1_dst,
  output logic [ID_W-1:0]                iss1_id,
  output logic                           iss2_valid,
  output logic [1:0]                     iss2_class,
  output logic [TAG_W-1:0]               iss2_src1,
  output logic [TAG_W-1:0]               iss2_src2,
  output logic [TAG_W-1:0]               iss2_dst,
  output logic [ID_W-1:0]                iss2_id
);

  // ---------------- per-entry state
  logic [DEPTH-1:0]             slot_valid, slot_rdy, slot_wr, issue_clear;
  logic [DEPTH-1:0][CLS_W-1:0]  slot_cls;
  logic [TAG_W-1:0]             slot_s1  [DEPTH];
  logic [TAG_W-1:0]             slot_s2  [DEPTH];
  logic [TAG_W-1:0]             slot_dst [DEPTH];
  logic [ID_W-1:0]              slot_id  [DEPTH];

  logic [CLS_W-1:0]             wr_cls [DEPTH];
  logic [TAG_W-1:0]             wr_s1  [DEPTH];
  logic [TAG_W-1:0]             wr_s2  [DEPTH];
  logic [TAG_W-1:0]             wr_dst [DEPTH];
  logic [ID_W-1:0]              wr_id  [DEPTH];
  logic [DEPTH-1:0]             wr_r1, wr_r2;

  // ---------------- allocation
  logic                         disp_accept;
  logic [DISP_W-1:0][DEPTH-1:0] lane_grant;

  iq_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .free_vec   (~slot_valid),
    .lane_valid (disp_valid),
    .accept     (disp_accept),
    .lane_grant (lane_grant)
  );

  assign disp_ready = disp_accept;

  // route each accepted lane's payload to the entry it was granted
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_wr[i] = 1'b0;
      wr_cls[i]  = '0;
      wr_s1[i]   = '0;
      wr_s2[i]   = '0;
      wr_dst[i]  = '0;
      wr_id[i]   = '0;
      wr_r1[i]   = 1'b0;
      wr_r2[i]   = 1'b0;
      for (int k = 0; k < DISP_W; k++) begin
        if (disp_accept && lane_grant[k][i]) begin
          slot_wr[i] = 1'b1;
          wr_cls[i]  = disp_class[k];
          wr_s1[i]   = disp_src1[k];
          wr_s2[i]   = disp_src2[k];
          wr_dst[i]  = disp_dst[k];
          wr_id[i]   = disp_id[k];
          wr_r1[i]   = disp_src1_rdy[k];
          wr_r2[i]   = disp_src2_rdy[k];
        end
      end
    end
  end

  // ---------------- entries
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    iq_slot #(.TAG_W(TAG_W), .ID_W(ID_W), .WAKE_W(WAKE_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .wr_en       (slot_wr[g]),
      .wr_cls      (wr_cls[g]),
      .wr_src1     (wr_s1[g]),
      .wr_src1_rdy (wr_r1[g]),
      .wr_src2     (wr_s2[g]),
      .wr_src2_rdy (wr_r2[g]),
      .wr_dst      (wr_dst[g]),
      .wr_id       (wr_id[g]),
      .clear       (issue_clear[g]),
      .wake_valid  (wake_valid),
      .wake_tag    (wake_tag),
      .valid_o     (slot_valid[g]),
      .ready_o     (slot_rdy[g]),
      .cls_o       (slot_cls[g]),
      .src1_o      (slot_s1[g]),
      .src2_o      (slot_s2[g]),
      .dst_o       (slot_dst[g]),
      .id_o        (slot_id[g])
    );
  end

  // ---------------- selection and divide window
  logic             div_idle, div_start;
  logic [DEPTH-1:0] pick1, pick2;

  iq_select #(.DEPTH(DEPTH)) u_select (
    .cand      (slot_valid & slot_rdy),
    .slot_cls  (slot_cls),
    .alu1_open (!flush && !alu1_busy),
    .alu2_open (!flush && !alu2_busy && div_idle),
    .pick1     (pick1),
    .pick2     (pick2)
  );

  iq_div_timer #(.DIV_CYCLES(DIV_CYCLES)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .idle  (div_idle)
  );

  assign issue_clear = pick1 | pick2;

  // one-hot read-out of the chosen entries
  always_comb begin
    iss1_class = '0; iss1_src1 = '0; iss1_src2 = '0; iss1_dst = '0; iss1_id = '0;
    iss2_class = '0; iss2_src1 = '0; iss2_src2 = '0; iss2_dst = '0; iss2_id = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick1[i]) begin
        iss1_class = slot_cls[i];
        iss1_src1  = slot_s1[i];
        iss1_src2  = slot_s2[i];
        iss1_dst   = slot_dst[i];
        iss1_id    = slot_id[i];
      end
      if (pick2[i]) begin
        iss2_class = slot_cls[i];
        iss2_src1  = slot_s1[i];
        iss2_src2  = slot_s2[i];
        iss2_dst   = slot_dst[i];
        iss2_id    = slot_id[i];
      end
    end
  end

  assign iss1_valid = (pick1 != '0);
  assign iss2_valid = (pick2 != '0);
  assign div_start  = iss2_valid && (iss2_class == CLS_DIV);

  // ---------------- assertions
  assert_port1_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_valid |-> ((iss1_class == CLS_SIMPLE) || (iss1_class == CLS_BRSH)));

  assert_port1_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alu1_busy |-> !iss1_valid);

  assert_port2_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iss2_valid |-> (iss2_class != CLS_BRSH));

  assert_ports_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick1 & pick2) == '0);

  assert_only_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick1 | pick2) & ~(slot_valid & slot_rdy)) == '0);

  assert_div_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss2_valid && (iss2_class == CLS_DIV)) |=> !iss2_valid);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_clear != '0) |=> ((slot_valid & $past(issue_clear)) == '0));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_valid == '0));

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!iss1_valid && !iss2_valid && !disp_ready));

endmodule

// File: tb/int_issue_queue_tb.sv
module int_issue_queue_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DISP_W     = 4;
  localparam int WAKE_W     = 3;
  localparam int TAG_W      = 6;
  localparam int ID_W       = 5;
  localparam int DIV_CYCLES = 5;

  logic                         clk = 1'b0;
  logic                         rst_n;
  logic                         flush;
  logic [DISP_W-1:0]            disp_valid;
  logic [DISP_W-1:0][1:0]       disp_class;
  logic [DISP_W-1:0][TAG_W-1:0] disp_src1, disp_src2, disp_dst;
  logic [DISP_W-1:0]            disp_src1_rdy, disp_src2_rdy;
  logic [DISP_W-1:0][ID_W-1:0]  disp_id;
  logic                         disp_ready;
  logic [WAKE_W-1:0]            wake_valid;
  logic [WAKE_W-1:0][TAG_W-1:0] wake_tag;
  logic                         alu1_busy, alu2_busy;
  logic                         iss1_valid, iss2_valid;
  logic [1:0]                   iss1_class, iss2_class;
  logic [TAG_W-1:0]             iss1_src1, iss1_src2, iss1_dst;
  logic [TAG_W-1:0]             iss2_src1, iss2_src2, iss2_dst;
  logic [ID_W-1:0]              iss1_id, iss2_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_issue_queue #(
    .DEPTH(DEPTH), .DISP_W(DISP_W), .WAKE_W(WAKE_W),
    .TAG_W(TAG_W), .ID_W(ID_W), .DIV_CYCLES(DIV_CYCLES)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_class(disp_class),
    .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
    .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy),
    .disp_dst(disp_dst), .disp_id(disp_id), .disp_ready(disp_ready),
    .wake_valid(wake_valid), .wake_tag(wake_tag),
    .alu1_busy(alu1_busy), .alu2_busy(alu2_busy),
    .iss1_valid(iss1_valid), .iss1_class(iss1_class), .iss1_src1(iss1_src1),
    .iss1_src2(iss1_src2), .iss1_dst(iss1_dst), .iss1_id(iss1_id),
    .iss2_valid(iss2_valid), .iss2_class(iss2_class), .iss2_src1(iss2_src1),
    .iss2_src2(iss2_src2), .iss2_dst(iss2_dst), .iss2_id(iss2_id)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  // bench-side picture of the queue
  bit               m_vld [DEPTH];
  bit               m_r1  [DEPTH];
  bit               m_r2  [DEPTH];
  logic [1:0]       m_cls [DEPTH];
  logic [TAG_W-1:0] m_s1  [DEPTH];
  logic [TAG_W-1:0] m_s2  [DEPTH];
  logic [TAG_W-1:0] m_dst [DEPTH];
  logic [ID_W-1:0]  m_id  [DEPTH];
  int               div_left;
  logic [31:0]      rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit woke(input logic [TAG_W-1:0] t);
    bit h = 1'b0;
    for (int w = 0; w < WAKE_W; w++) if (wake_valid[w] && wake_tag[w] == t) h = 1'b1;
    return h;
  endfunction

  function automatic bit can_go(input int i);
    return m_vld[i] && m_r1[i] && m_r2[i];
  endfunction

  function automatic logic [31:0] pack_slot(input int i);
    return {7'd0, m_cls[i], m_s1[i], m_s2[i], m_dst[i], m_id[i]};
  endfunction

  task automatic clr_inputs();
    flush = 1'b0; disp_valid = '0; disp_class = '0; disp_src1 = '0; disp_src2 = '0;
    disp_src1_rdy = '0; disp_src2_rdy = '0; disp_dst = '0; disp_id = '0;
    wake_valid = '0; wake_tag = '0; alu1_busy = 1'b0; alu2_busy = 1'b0;
  endtask

  task automatic lane(input int k, input logic [1:0] c, input logic [TAG_W-1:0] a,
                      input bit ar, input logic [TAG_W-1:0] b, input bit br,
                      input logic [TAG_W-1:0] d, input logic [ID_W-1:0] id);
    disp_valid[k] = 1'b1; disp_class[k] = c; disp_src1[k] = a; disp_src1_rdy[k] = ar;
    disp_src2[k] = b; disp_src2_rdy[k] = br; disp_dst[k] = d; disp_id[k] = id;
  endtask

  // compare one cycle against the bench picture, then advance the picture
  task automatic cycle(input string tag);
    int e1, e2, nfree, noff;
    bit acc;
    bit was_free [DEPTH];
    bit taken [DEPTH];
    #1;
    e1 = -1; e2 = -1; nfree = 0; noff = 0;
    if (!flush && !alu1_busy) begin
      for (int i = DEPTH-1; i >= 0; i--) if (can_go(i) && m_cls[i] == 2'd1) e1 = i;
      if (e1 < 0) for (int i = DEPTH-1; i >= 0; i--) if (can_go(i) && m_cls[i] == 2'd0) e1 = i;
    end
    if (!flush && !alu2_busy && div_left == 0) begin
      for (int i = DEPTH-1; i >= 0; i--) if (can_go(i) && m_cls[i][1]) e2 = i;
      if (e2 < 0)
        for (int i = DEPTH-1; i >= 0; i--) if (can_go(i) && m_cls[i] == 2'd0 && i != e1) e2 = i;
    end
    for (int i = 0; i < DEPTH; i++) if (!m_vld[i]) nfree++;
    for (int k = 0; k < DISP_W; k++) if (disp_valid[k]) noff++;
    acc = !flush && (nfree >= noff);

    chk(disp_ready === acc, "R1", "disp_ready", 32'(disp_ready), 32'(acc));
    chk(iss1_valid === (e1 >= 0), tag, "iss1_valid", 32'(iss1_valid), 32'(e1 >= 0));
    if (e1 >= 0 && iss1_valid === 1'b1)
      chk({7'd0, iss1_class, iss1_src1, iss1_src2, iss1_dst, iss1_id} === pack_slot(e1),
          "R7", "iss1 payload",
          {7'd0, iss1_class, iss1_src1, iss1_src2, iss1_dst, iss1_id}, pack_slot(e1));
    chk(iss2_valid === (e2 >= 0), tag, "iss2_valid", 32'(iss2_valid), 32'(e2 >= 0));
    if (e2 >= 0 && iss2_valid === 1'b1)
      chk({7'd0, iss2_class, iss2_src1, iss2_src2, iss2_dst, iss2_id} === pack_slot(e2),
          "R7", "iss2 payload",
          {7'd0, iss2_class, iss2_src1, iss2_src2, iss2_dst, iss2_id}, pack_slot(e2));

    // advance the picture
    if (!flush && e2 >= 0 && m_cls[e2] == 2'd3) div_left = DIV_CYCLES;
    else if (div_left > 0) div_left--;
    for (int i = 0; i < DEPTH; i++) begin was_free[i] = !m_vld[i]; taken[i] = 1'b0; end
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    end else begin
      if (e1 >= 0) m_vld[e1] = 1'b0;
      if (e2 >= 0) m_vld[e2] = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (woke(m_s1[i])) m_r1[i] = 1'b1;
        if (woke(m_s2[i])) m_r2[i] = 1'b1;
      end
      if (acc) begin
        for (int k = 0; k < DISP_W; k++) begin
          if (disp_valid[k]) begin
            int s = -1;
            for (int i = DEPTH-1; i >= 0; i--) if (was_free[i] && !taken[i]) s = i;
            if (s >= 0) begin
              taken[s] = 1'b1; m_vld[s] = 1'b1; m_cls[s] = disp_class[k];
              m_s1[s] = disp_src1[k]; m_s2[s] = disp_src2[k];
              m_dst[s] = disp_dst[k]; m_id[s] = disp_id[k];
              m_r1[s] = disp_src1_rdy[k] | woke(disp_src1[k]);
              m_r2[s] = disp_src2_rdy[k] | woke(disp_src2[k]);
            end
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] step_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    clr_inputs();
    rst_n = 1'b0;
    div_left = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 0; m_r1[i] = 0; m_r2[i] = 0; m_cls[i] = '0;
      m_s1[i] = '0; m_s2[i] = '0; m_dst[i] = '0; m_id[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    #1;
    chk(disp_ready === 1'b1, "R1", "ready after reset", 32'(disp_ready), 1);
    chk(!iss1_valid && !iss2_valid, "R1", "no issue after reset",
        {30'd0, iss1_valid, iss2_valid}, 0);
    cycle("R1");

    // R2: four plain ready instructions land in entries 0..3
    lane(0, 2'd0, 6'd1, 1, 6'd2, 1, 6'd20, 5'd1);
    lane(1, 2'd0, 6'd1, 1, 6'd2, 1, 6'd21, 5'd2);
    lane(2, 2'd0, 6'd1, 1, 6'd2, 1, 6'd22, 5'd3);
    lane(3, 2'd0, 6'd1, 1, 6'd2, 1, 6'd23, 5'd4);
    cycle("R2");
    clr_inputs();
    #1;
    chk(iss1_valid && iss1_id == 5'd1, "R2", "port1 takes lane0 entry", 32'(iss1_id), 1);
    chk(iss2_valid && iss2_id == 5'd2, "R5", "port2 takes next plain entry", 32'(iss2_id), 2);
    cycle("R2");
    cycle("R2");
    cycle("R2");

    // R3: wakeup paths
    lane(0, 2'd0, 6'd10, 0, 6'd2, 1, 6'd30, 5'd5);
    cycle("R3");
    clr_inputs();
    cycle("R3");
    wake_valid = 3'b000; wake_tag[0] = 6'd10;
    cycle("R3");
    clr_inputs();
    #1;
    chk(!iss1_valid, "R3", "invalid wakeup ignored", 32'(iss1_valid), 0);
    wake_valid = 3'b100; wake_tag[2] = 6'd10;
    cycle("R3");
    clr_inputs();
    #1;
    chk(iss1_valid && iss1_id == 5'd5, "R3", "issue after wakeup", 32'(iss1_id), 5);
    cycle("R3");
    lane(0, 2'd0, 6'd12, 0, 6'd13, 0, 6'd31, 5'd6);
    wake_valid = 3'b011; wake_tag[0] = 6'd13; wake_tag[1] = 6'd12;
    cycle("R3");
    clr_inputs();
    #1;
    chk(iss1_valid && iss1_id == 5'd6, "R3", "same-cycle wakeup kept", 32'(iss1_id), 6);
    cycle("R3");

    // R4: branch/shift preferred on port 1, busy blocks
    alu1_busy = 1; alu2_busy = 1;
    lane(0, 2'd0, 6'd1, 1, 6'd1, 1, 6'd40, 5'd7);
    lane(1, 2'd1, 6'd1, 1, 6'd1, 1, 6'd41, 5'd8);
    lane(2, 2'd1, 6'd1, 1, 6'd1, 1, 6'd42, 5'd9);
    cycle("R4");
    disp_valid = '0;
    #1;
    chk(!iss1_valid && !iss2_valid, "R4", "busy ALUs issue nothing",
        {30'd0, iss1_valid, iss2_valid}, 0);
    cycle("R4");
    alu1_busy = 0;
    #1;
    chk(iss1_valid && iss1_id == 5'd8, "R4", "branch beats lower plain", 32'(iss1_id), 8);
    chk(!iss2_valid, "R5", "port2 busy", 32'(iss2_valid), 0);
    cycle("R4");
    alu2_busy = 0;
    #1;
    chk(iss1_valid && iss1_id == 5'd9, "R4", "second branch", 32'(iss1_id), 9);
    chk(iss2_valid && iss2_id == 5'd7, "R5", "plain to port2", 32'(iss2_id), 7);
    cycle("R4");
    clr_inputs();

    // R6: divide closes port 2
    lane(0, 2'd3, 6'd1, 1, 6'd1, 1, 6'd50, 5'd10);
    lane(1, 2'd2, 6'd1, 1, 6'd1, 1, 6'd51, 5'd11);
    lane(2, 2'd0, 6'd1, 1, 6'd1, 1, 6'd52, 5'd12);
    lane(3, 2'd0, 6'd1, 1, 6'd1, 1, 6'd53, 5'd13);
    cycle("R6");
    clr_inputs();
    #1;
    chk(iss2_valid && iss2_id == 5'd10, "R5", "divide to port2", 32'(iss2_id), 10);
    chk(iss1_valid && iss1_id == 5'd12, "R4", "plain to port1", 32'(iss1_id), 12);
    cycle("R6");
    for (int c = 0; c < DIV_CYCLES; c++) begin
      #1;
      chk(!iss2_valid, "R6", "port2 closed during divide", 32'(iss2_valid), 0);
      cycle("R6");
    end
    #1;
    chk(iss2_valid && iss2_id == 5'd11, "R6", "multiply after divide", 32'(iss2_id), 11);
    cycle("R6");

    // R1: fill to full, then back-pressure
    alu1_busy = 1; alu2_busy = 1;
    for (int b = 0; b < DEPTH/DISP_W; b++) begin
      for (int k = 0; k < DISP_W; k++)
        lane(k, 2'd0, 6'd1, 1, 6'd1, 1, 6'(b*4+k), 5'(b*4+k));
      cycle("R1");
    end
    disp_valid = '0;
    lane(0, 2'd0, 6'd1, 1, 6'd1, 1, 6'd60, 5'd20);
    #1;
    chk(disp_ready === 1'b0, "R1", "full queue refuses", 32'(disp_ready), 0);
    cycle("R1");
    disp_valid = '0;
    alu1_busy = 0;
    cycle("R7");
    alu1_busy = 1;
    lane(0, 2'd0, 6'd1, 1, 6'd1, 1, 6'd61, 5'd21);
    lane(1, 2'd0, 6'd1, 1, 6'd1, 1, 6'd62, 5'd22);
    #1;
    chk(disp_ready === 1'b0, "R1", "two offered one free", 32'(disp_ready), 0);
    cycle("R1");
    disp_valid = '0;
    lane(2, 2'd0, 6'd1, 1, 6'd1, 1, 6'd63, 5'd23);
    #1;
    chk(disp_ready === 1'b1, "R1", "one offered one free", 32'(disp_ready), 1);
    cycle("R7");

    // R8: flush
    clr_inputs();
    alu1_busy = 1; alu2_busy = 1;
    flush = 1;
    lane(0, 2'd0, 6'd1, 1, 6'd1, 1, 6'd5, 5'd24);
    #1;
    chk(disp_ready === 1'b0, "R8", "dispatch refused in flush", 32'(disp_ready), 0);
    cycle("R8");
    clr_inputs();
    #1;
    chk(!iss1_valid && !iss2_valid, "R8", "empty after flush",
        {30'd0, iss1_valid, iss2_valid}, 0);
    chk(disp_ready === 1'b1, "R8", "ready after flush", 32'(disp_ready), 1);
    cycle("R8");

    // mixed traffic against the bench picture
    for (int n = 0; n < 4000; n++) begin
      clr_inputs();
      rng = step_rng(rng);
      for (int k = 0; k < DISP_W; k++) begin
        if (rng[k]) begin
          logic [31:0] r2;
          r2 = step_rng(rng ^ 32'(k * 977 + 1));
          lane(k, r2[1:0], {3'd0, r2[4:2]}, r2[5], {3'd0, r2[8:6]}, r2[9],
               6'(r2[15:10]), 5'(n + k));
        end
      end
      wake_valid = rng[6:4];
      wake_tag[0] = {3'd0, rng[9:7]};
      wake_tag[1] = {3'd0, rng[12:10]};
      wake_tag[2] = {3'd0, rng[15:13]};
      alu1_busy = (rng[18:16] == 3'd0);
      alu2_busy = (rng[21:19] == 3'd0);
      flush = (rng[27:22] == 6'd0);
      cycle("R7");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule